// File: doc/BRIEF.md
# Timeout-Framed SPI Packet Receiver

This block receives bytes from an SPI master over a link that has no chip-select line and no return data line. Serial data arrives on `mosi`. It is captured on each rising edge of `sclk`, and both lines rest low when the link is idle. The system clock oversamples both lines. Bits are gathered into 8-bit words, most significant bit first. Each finished word is presented for one cycle together with its position inside a packet of 28 bytes.

The link carries no framing signal, so the block finds packet boundaries by counting bytes. The last byte of a packet raises a completion pulse, and the next byte starts again at position zero. An idle timer restarts on every rising edge of `sclk`. If no edge arrives within `IDLE_CYCLES` system clocks, the bit and byte counters are cleared, and the next edge starts a fresh packet. When the timer expires while a byte or a packet is incomplete, the partial data is dropped and a fragment-error pulse is raised.

The system clock must run at least eight times faster than `sclk`. Both serial inputs pass through two-flop synchronisers before use.

Top module: `spi_pkt_rx`

## Requirements
- R1: While `rst` is high and on the first cycles after it falls, `byte_valid`, `byte_data`, `byte_idx`, `pkt_done` and `frag_err` are all zero.
- R2: Each bit is the value of `mosi` at a rising edge of `sclk`, and the first bit of a byte lands in `byte_data[7]` (most significant bit first).
- R3: `byte_valid` is high for exactly one system cycle after every eighth rising `sclk` edge of a byte.
- R4: `byte_idx` counts 0, 1, ..., 27 across the bytes of a packet. When bytes keep arriving without a pause, the byte after index 27 carries index 0.
- R5: `pkt_done` is a one-cycle pulse that appears only together with `byte_valid` for the byte at index 27.
- R6: If more than `IDLE_CYCLES` system cycles pass without a rising `sclk` edge while a byte is partly received, `frag_err` pulses once and the partial bits are discarded. The next eight edges form a byte at index 0.
- R7: If the timer expires after whole bytes of an unfinished packet, `frag_err` pulses once and the next byte carries index 0.
- R8: A pause shorter than `IDLE_CYCLES` between two rising edges changes nothing: the bit position and the byte index continue.
- R9: Timer expiry after a complete packet raises no `frag_err`.
- R10: Changes of `mosi` while `sclk` is high, or on its falling edge, do not alter the received data.
- R11: `frag_err` and `byte_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the `sclk` rate |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the master, idle low |
| mosi | input | 1 | Serial data from the master, idle low |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |
| byte_data | output | 8 | Received byte, valid with `byte_valid` |
| byte_idx | output | 5 | Position of the byte in its packet, 0 to 27 |
| pkt_done | output | 1 | Pulse with the last byte of a packet |
| frag_err | output | 1 | Pulse when a timeout drops a partial byte or packet |

## Verification
A bit counter that is out of step shows up as shifted or rotated data on the next `byte_valid`, at most eight `sclk` edges later. A wrong byte counter shows up as a wrong `byte_idx` on the next byte, and as `pkt_done` missing from index 27 or placed on another index. A timer that fails to clear the counters shows up on the first byte after a long pause: the index is non-zero and old bits are mixed into the data. A timer that clears too early breaks up bytes that contain short pauses. A wrong decision about pending data shows up as a missing or extra `frag_err` within `IDLE_CYCLES` plus a few cycles of the last edge.

// File: rtl/spi_pkt_pkg.sv
package spi_pkt_pkg;

    localparam int DATA_W  = 8;
    localparam int PKT_LEN = 28;
    localparam int IDX_W   = $clog2(PKT_LEN);
    localparam int BIT_W   = $clog2(DATA_W);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [BIT_W-1:0]  bitpos_t;

    typedef struct packed {
        logic  valid;
        word_t data;
        idx_t  idx;
        logic  last;
    } rx_beat_t;

    function automatic logic is_last_idx(idx_t i);
        return i == idx_t'(PKT_LEN - 1);
    endfunction

    function automatic idx_t next_idx(idx_t i);
        return is_last_idx(i) ? '0 : i + idx_t'(1);
    endfunction

endpackage

// File: rtl/spi_pkt_sync.sv
module spi_pkt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_in,
    input  logic mosi_in,
    output logic mosi_q,
    output logic rise
);
    logic [STAGES-1:0] sclk_pipe;
    logic [STAGES-1:0] mosi_pipe;
    logic              sclk_prev;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) begin
                        sclk_pipe[0] <= 1'b0;
                        mosi_pipe[0] <= 1'b0;
                    end else begin
                        sclk_pipe[0] <= sclk_in;
                        mosi_pipe[0] <= mosi_in;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) begin
                        sclk_pipe[s] <= 1'b0;
                        mosi_pipe[s] <= 1'b0;
                    end else begin
                        sclk_pipe[s] <= sclk_pipe[s-1];
                        mosi_pipe[s] <= mosi_pipe[s-1];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sclk_prev <= 1'b0;
        else     sclk_prev <= sclk_pipe[STAGES-1];
    end

    assign rise   = sclk_pipe[STAGES-1] & ~sclk_prev;
    assign mosi_q = mosi_pipe[STAGES-1];

    // a detected edge cannot repeat on the following cycle
    p_rise_single_r3: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/spi_pkt_shift.sv
module spi_pkt_shift
    import spi_pkt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rise,
    input  logic    bit_in,
    input  logic    flush,
    output bitpos_t bit_cnt,
    output logic    fire,
    output word_t   word
);
    word_t sh;

    assign fire = rise && (bit_cnt == bitpos_t'(DATA_W - 1));
    assign word = {sh[DATA_W-2:0], bit_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            bit_cnt <= '0;
        end else if (flush) begin
            sh      <= '0;
            bit_cnt <= '0;
        end else if (rise) begin
            sh      <= word;
            bit_cnt <= bit_cnt + bitpos_t'(1);
        end
    end

    // a flush and an edge are never seen together (timer restarts on edges)
    p_flush_no_edge_r6: assert property (@(posedge clk) disable iff (rst)
        flush |-> !rise);
    p_flush_clears_r6: assert property (@(posedge clk) disable iff (rst)
        flush |=> bit_cnt == '0);
endmodule

// File: rtl/spi_pkt_framer.sv
module spi_pkt_framer
    import spi_pkt_pkg::*;
#(
    parameter int IDLE_CYCLES = 500000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     rise,
    input  logic     fire,
    input  word_t    word,
    input  bitpos_t  bit_cnt,
    output logic     flush,
    output idx_t     byte_cnt,
    output rx_beat_t beat,
    output logic     frag
);
    localparam int TW = $clog2(IDLE_CYCLES + 1);
    localparam logic [TW-1:0] T_LAST = TW'(IDLE_CYCLES - 1);
    localparam logic [TW-1:0] T_SAT  = TW'(IDLE_CYCLES);

    logic [TW-1:0] idle_cnt;
    logic          pending;

    assign pending = (bit_cnt != '0) || (byte_cnt != '0);
    assign flush   = (idle_cnt == T_LAST) && !rise;

    always_ff @(posedge clk) begin
        if (rst)                  idle_cnt <= '0;
        else if (rise)            idle_cnt <= '0;
        else if (idle_cnt != T_SAT) idle_cnt <= idle_cnt + TW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_cnt <= '0;
            beat     <= '0;
            frag     <= 1'b0;
        end else begin
            beat.valid <= fire;
            beat.last  <= fire && is_last_idx(byte_cnt);
            frag       <= flush && pending;
            if (fire) begin
                beat.data <= word;
                beat.idx  <= byte_cnt;
            end
            if (flush)     byte_cnt <= '0;
            else if (fire) byte_cnt <= next_idx(byte_cnt);
        end
    end

    p_idx_range_r4: assert property (@(posedge clk) disable iff (rst)
        beat.valid |-> beat.idx < idx_t'(PKT_LEN));
    p_done_last_r5: assert property (@(posedge clk) disable iff (rst)
        beat.last |-> beat.valid && is_last_idx(beat.idx));
    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        beat.last |-> byte_cnt == '0);
endmodule

// File: rtl/spi_pkt_rx.sv
module spi_pkt_rx
    import spi_pkt_pkg::*;
#(
    parameter int IDLE_CYCLES = 500000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk,
    input  logic             mosi,
    output logic             byte_valid,
    output logic [DATA_W-1:0] byte_data,
    output logic [IDX_W-1:0]  byte_idx,
    output logic             pkt_done,
    output logic             frag_err
);
    logic     rise, mosi_q, fire, flush, frag;
    bitpos_t  bit_cnt;
    word_t    word;
    idx_t     byte_cnt;
    rx_beat_t beat;

    spi_pkt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sclk_in(sclk), .mosi_in(mosi),
        .mosi_q(mosi_q), .rise(rise)
    );

    spi_pkt_shift u_shift (
        .clk(clk), .rst(rst), .rise(rise), .bit_in(mosi_q), .flush(flush),
        .bit_cnt(bit_cnt), .fire(fire), .word(word)
    );

    spi_pkt_framer #(.IDLE_CYCLES(IDLE_CYCLES)) u_framer (
        .clk(clk), .rst(rst), .rise(rise), .fire(fire), .word(word),
        .bit_cnt(bit_cnt), .flush(flush), .byte_cnt(byte_cnt),
        .beat(beat), .frag(frag)
    );

    assign byte_valid = beat.valid;
    assign byte_data  = beat.data;
    assign byte_idx   = beat.idx;
    assign pkt_done   = beat.last;
    assign frag_err   = frag;

    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);
    p_no_overlap_r11: assert property (@(posedge clk) disable iff (rst)
        !(byte_valid && frag_err));
    p_frag_clean_r6: assert property (@(posedge clk) disable iff (rst)
        frag_err |-> bit_cnt == '0 && byte_cnt == '0);
    p_frag_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        frag_err |=> !frag_err);
endmodule

// File: tb/tb_spi_pkt_rx.sv
module tb_spi_pkt_rx;
    localparam int CLK_PERIOD = 10;
    localparam int IDLE = 200;
    localparam int H = 8;

    logic clk = 0, rst = 1, sclk = 0, mosi = 0;
    logic       byte_valid, pkt_done, frag_err;
    logic [7:0] byte_data;
    logic [4:0] byte_idx;

    int total = 0, bad = 0;
    int cap_n = 0, done_n = 0, frag_n = 0, overlap_n = 0, long_valid_n = 0;
    logic [7:0] cap_data [0:127];
    logic [4:0] cap_idx  [0:127];
    logic       cap_done [0:127];
    logic       prev_valid = 0;
    int         cyc = 0;

    spi_pkt_rx #(.IDLE_CYCLES(IDLE)) dut (
        .clk(clk), .rst(rst), .sclk(sclk), .mosi(mosi),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_idx(byte_idx),
        .pkt_done(pkt_done), .frag_err(frag_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (byte_valid && cap_n < 128) begin
                cap_data[cap_n] = byte_data;
                cap_idx[cap_n]  = byte_idx;
                cap_done[cap_n] = pkt_done;
                cap_n = cap_n + 1;
            end
            if (pkt_done) done_n = done_n + 1;
            if (frag_err) frag_n = frag_n + 1;
            if (byte_valid && frag_err) overlap_n = overlap_n + 1;
            if (byte_valid && prev_valid) long_valid_n = long_valid_n + 1;
            prev_valid = byte_valid;
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            bad = bad + 1; total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_log();
        cap_n = 0; done_n = 0; frag_n = 0; overlap_n = 0; long_valid_n = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; sclk = 0; mosi = 0;
        wait_cyc(4);
        rst = 0;
        clear_log();
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        mosi = b;
        wait_cyc(H);
        sclk = 1;
        wait_cyc(H/2);
        if (glitch) mosi = ~b;
        wait_cyc(H/2);
        sclk = 0;
        if (glitch) mosi = ~b;
    endtask

    task automatic send_byte(input logic [7:0] v, input bit glitch);
        for (int i = 7; i >= 0; i--) send_bit(v[i], glitch);
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 37 + 5);
    endfunction

    task automatic t_reset();
        @(negedge clk);
        rst = 1; wait_cyc(3);
        chk(byte_valid == 0 && pkt_done == 0 && frag_err == 0, "R1 strobes", byte_valid, 0);
        chk(byte_data == 0 && byte_idx == 0, "R1 data/idx", byte_data, 0);
        rst = 0; wait_cyc(3);
        chk(byte_valid == 0 && frag_err == 0 && byte_idx == 0, "R1 after release", byte_idx, 0);
        clear_log();
    endtask

    task automatic t_msb_first();
        do_reset();
        send_byte(8'hB4, 0);
        wait_cyc(6);
        chk(cap_n == 1, "R3 one strobe per byte", cap_n, 1);
        chk(cap_data[0] == 8'hB4, "R2 msb first", cap_data[0], 8'hB4);
        chk(cap_idx[0] == 0, "R4 first idx", cap_idx[0], 0);
        chk(long_valid_n == 0, "R3 single-cycle strobe", long_valid_n, 0);
    endtask

    task automatic t_packets();
        int errs = 0, idx_errs = 0, done_errs = 0;
        do_reset();
        for (int i = 0; i < 56; i++) send_byte(pat(i), 0);
        wait_cyc(6);
        chk(cap_n == 56, "R3 byte count", cap_n, 56);
        for (int i = 0; i < 56; i++) begin
            if (cap_data[i] != pat(i)) errs++;
            if (cap_idx[i] != 5'(i % 28)) idx_errs++;
            if (cap_done[i] != ((i % 28) == 27)) done_errs++;
        end
        chk(errs == 0, "R2 packet data", errs, 0);
        chk(idx_errs == 0, "R4 index sequence and wrap", idx_errs, 0);
        chk(done_errs == 0 && done_n == 2, "R5 done on idx 27", done_n, 2);
        wait_cyc(IDLE + 20);
        chk(frag_n == 0, "R9 no frag after full packet", frag_n, 0);
    endtask

    task automatic t_partial_byte();
        do_reset();
        send_bit(1, 0); send_bit(1, 0); send_bit(1, 0);
        wait_cyc(IDLE + 20);
        chk(frag_n == 1, "R6 frag on partial byte", frag_n, 1);
        chk(overlap_n == 0, "R11 no overlap", overlap_n, 0);
        send_byte(8'h35, 0);
        wait_cyc(6);
        chk(cap_n == 1 && cap_data[0] == 8'h35, "R6 realigned data", cap_data[0], 8'h35);
        chk(cap_idx[0] == 0, "R6 realigned idx", cap_idx[0], 0);
    endtask

    task automatic t_partial_pkt();
        do_reset();
        for (int i = 0; i < 5; i++) send_byte(pat(i), 0);
        wait_cyc(IDLE + 20);
        chk(frag_n == 1, "R7 frag on partial packet", frag_n, 1);
        send_byte(8'hC3, 0);
        wait_cyc(6);
        chk(cap_n == 6 && cap_idx[5] == 0, "R7 idx restarts", cap_idx[5], 0);
        chk(overlap_n == 0, "R11 no overlap", overlap_n, 0);
    endtask

    task automatic t_short_gap();
        do_reset();
        send_byte(8'h11, 0);
        send_bit(1, 0); send_bit(0, 0); send_bit(1, 0); send_bit(0, 0);
        wait_cyc(IDLE - 60);
        send_bit(0, 0); send_bit(1, 0); send_bit(1, 0); send_bit(0, 0);
        wait_cyc(6);
        chk(frag_n == 0, "R8 no frag on short gap", frag_n, 0);
        chk(cap_n == 2 && cap_data[1] == 8'hA6, "R8 data across gap", cap_data[1], 8'hA6);
        chk(cap_idx[1] == 1, "R8 idx continues", cap_idx[1], 1);
    endtask

    task automatic t_glitch();
        do_reset();
        send_byte(8'h5C, 1);
        send_byte(8'hE1, 1);
        wait_cyc(6);
        chk(cap_n == 2 && cap_data[0] == 8'h5C, "R10 high-phase change ignored", cap_data[0], 8'h5C);
        chk(cap_data[1] == 8'hE1, "R10 second byte", cap_data[1], 8'hE1);
    endtask

    initial begin
        t_reset();
        t_msb_first();
        t_packets();
        t_partial_byte();
        t_partial_pkt();
        t_short_gap();
        t_glitch();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule